// File: doc/BRIEF.md
# Video Processor Port Decoder

This block is the register-port front end of a video display processor. It sits on a 16-bit processor bus that has separate upper and lower byte strobes. For each bus access it works out which port is addressed and turns writes into single-cycle word strobes. It answers reads with a full 16-bit word. The block recognises four targets: a data port, a control port, a counter read port and a sound-generator window. The state machines behind the data and control ports and the sound generator are outside the block. They appear here only as write strobes with their data and as read-value inputs.

A transfer is one cycle with `bus_sel` high. All results are registered and appear on the cycle after the transfer. Bits A23..A8 must equal the `BASE` parameter. Below that, bits A7..A2 choose the port, so bit A1 and the byte lane make four mirrored byte addresses for each port.

A byte write to the data or control port is widened to a word that carries the written byte in both halves. The sound generator takes bytes only on the odd lane. An even-lane write to the sound window goes to a separate unused-access sink instead.

Top module: `vdp_port_decode`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, all four write strobes are low and `bus_rdata` is 0x0000.
- R2: Bits A7..A2 of an in-window access select the port. The codes are: 0 = data port (byte 0x00), 1 = control port (0x04), 2 = counter port (0x08), 4 and 5 = sound window (0x10, 0x14). A1 has no effect on which port is selected.
- R3: A write with both strobes to the data or control port raises that port's strobe for exactly one cycle, on the cycle after the transfer, with `bus_wdata` on its data output. No other strobe rises.
- R4: A byte write to the data or control port delivers a word with the byte in both halves. With only `bus_uds` asserted the byte is `bus_wdata[15:8]`. With only `bus_lds` asserted it is `bus_wdata[7:0]`.
- R5: A write with neither strobe asserted raises no strobe.
- R6: A sound-window write with `bus_lds` asserted raises `snd_we` for one cycle, with `snd_wdata` = `bus_wdata[7:0]`.
- R7: A sound-window write with only `bus_uds` asserted raises `unused_we` instead of `snd_we`, with `unused_wdata` = `bus_wdata[15:8]`.
- R8: A read ignores both strobes and loads all 16 bits of `bus_rdata` on the next cycle. A data-port read returns `dport_rdata` and a control-port read returns `cport_rdata`. `bus_rdata` then holds until the next in-window read.
- R9: A counter-port read returns the value of `cnt_in` on the cycle of the transfer.
- R10: An in-window read of any offset code other than 0, 1 or 2 returns 0xFFFF. A write to codes 2, 3, 6 and above raises no strobe.
- R11: An access with A23..A8 not equal to `BASE` raises no strobe and leaves `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 23 | Word address A23..A1 |
| bus_uds | input | 1 | Upper byte strobe, active high |
| bus_lds | input | 1 | Lower byte strobe, active high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dport_rdata | input | 16 | Value returned by a data-port read |
| cport_rdata | input | 16 | Value returned by a control-port read |
| cnt_in | input | 16 | Live counter value |
| dport_we | output | 1 | Data-port write pulse |
| dport_wdata | output | 16 | Data-port write word |
| cport_we | output | 1 | Control-port write pulse |
| cport_wdata | output | 16 | Control-port write word |
| snd_we | output | 1 | Sound-generator write pulse |
| snd_wdata | output | 8 | Sound-generator byte |
| unused_we | output | 1 | Even-lane sound-window write pulse |
| unused_wdata | output | 8 | Byte of the even-lane write |

## Verification
On every cycle the assertions check the following:
- At most one write strobe is high.
- Every data or control pulse follows a write transfer.
- A byte write always shows equal word halves.
- Sound writes only follow an odd-lane strobe.
- Control and unmapped reads return the right word.
- Out-of-window accesses leave the outputs untouched.

Only the bench's scenarios show the rest:
- Which byte is picked for duplication.
- That A1 mirrors a port.
- That pulses last a single cycle.
- That counter reads capture the value of the transfer cycle.
- That read data holds between reads.

// File: rtl/vdp_port_decode.sv
module vdp_port_decode #(
  parameter int          ADDR_W   = 23,
  parameter logic [15:0] BASE     = 16'hC000,
  parameter logic [15:0] UNMAPPED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W:1]   bus_addr,
  input  logic              bus_uds,
  input  logic              bus_lds,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [15:0]       dport_rdata,
  input  logic [15:0]       cport_rdata,
  input  logic [15:0]       cnt_in,
  output logic              dport_we,
  output logic [15:0]       dport_wdata,
  output logic              cport_we,
  output logic [15:0]       cport_wdata,
  output logic              snd_we,
  output logic [7:0]        snd_wdata,
  output logic              unused_we,
  output logic [7:0]        unused_wdata
);
  localparam logic [5:0] OFF_DATA = 6'd0;
  localparam logic [5:0] OFF_CTRL = 6'd1;
  localparam logic [5:0] OFF_CNT  = 6'd2;
  localparam logic [5:0] OFF_SND0 = 6'd4;
  localparam logic [5:0] OFF_SND1 = 6'd5;

  logic        hit, wr_ok, rd_ok, is_snd;
  logic [5:0]  off;
  logic [7:0]  lane;
  logic [15:0] wword, rword;

  assign hit    = bus_addr[ADDR_W:8] == BASE;
  assign off    = bus_addr[7:2];
  assign is_snd = (off == OFF_SND0) || (off == OFF_SND1);
  assign wr_ok  = bus_sel && bus_wr && hit && (bus_uds || bus_lds);
  assign rd_ok  = bus_sel && !bus_wr && hit;
  assign lane   = bus_uds ? bus_wdata[15:8] : bus_wdata[7:0];
  assign wword  = (bus_uds && bus_lds) ? bus_wdata : {lane, lane};

  always_comb begin
    case (off)
      OFF_DATA: rword = dport_rdata;
      OFF_CTRL: rword = cport_rdata;
      OFF_CNT:  rword = cnt_in;
      default:  rword = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dport_we     <= 1'b0;
      cport_we     <= 1'b0;
      snd_we       <= 1'b0;
      unused_we    <= 1'b0;
      dport_wdata  <= '0;
      cport_wdata  <= '0;
      snd_wdata    <= '0;
      unused_wdata <= '0;
      bus_rdata    <= '0;
    end else begin
      dport_we  <= wr_ok && (off == OFF_DATA);
      cport_we  <= wr_ok && (off == OFF_CTRL);
      snd_we    <= wr_ok && is_snd && bus_lds;
      unused_we <= wr_ok && is_snd && !bus_lds;
      if (wr_ok && off == OFF_DATA) dport_wdata <= wword;
      if (wr_ok && off == OFF_CTRL) cport_wdata <= wword;
      if (wr_ok && is_snd && bus_lds) snd_wdata <= bus_wdata[7:0];
      if (wr_ok && is_snd && !bus_lds) unused_wdata <= bus_wdata[15:8];
      if (rd_ok) bus_rdata <= rword;
    end
  end
endmodule

// File: rtl/vdp_port_decode_chk.sv
module vdp_port_decode_chk #(
  parameter int          ADDR_W   = 23,
  parameter logic [15:0] BASE     = 16'hC000,
  parameter logic [15:0] UNMAPPED = 16'hFFFF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [ADDR_W:1] bus_addr,
  input logic            bus_uds,
  input logic            bus_lds,
  input logic [15:0]     bus_rdata,
  input logic [15:0]     cport_rdata,
  input logic            dport_we,
  input logic [15:0]     dport_wdata,
  input logic            cport_we,
  input logic            snd_we,
  input logic            unused_we
);
  logic in_win;
  assign in_win = bus_addr[ADDR_W:8] == BASE;

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dport_we, cport_we, snd_we, unused_we}));

  a_r3_pulse_has_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dport_we || cport_we) |-> $past(bus_sel && bus_wr));

  a_r4_byte_halves_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (dport_we && $past(bus_uds ^ bus_lds)) |-> dport_wdata[15:8] == dport_wdata[7:0]);

  a_r6_odd_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    snd_we |-> $past(bus_lds));

  a_r8_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && in_win && bus_addr[7:2] == 6'd1)
      |-> bus_rdata == $past(cport_rdata));

  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !bus_wr && in_win && bus_addr[7:2] > 6'd2)
      |-> bus_rdata == UNMAPPED);

  a_r11_out_of_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !in_win)
      |-> (!dport_we && !cport_we && !snd_we && !unused_we && $stable(bus_rdata)));
endmodule

bind vdp_port_decode vdp_port_decode_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .UNMAPPED(UNMAPPED)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_rdata(bus_rdata), .cport_rdata(cport_rdata),
  .dport_we(dport_we), .dport_wdata(dport_wdata), .cport_we(cport_we),
  .snd_we(snd_we), .unused_we(unused_we)
);

// File: tb/test_vdp_port_decode.sv
`timescale 1ns/1ps
module test_vdp_port_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_uds = 1'b0, bus_lds = 1'b0;
  logic [23:1] bus_addr = '0;
  logic [15:0] bus_wdata = '0, dport_rdata = '0, cport_rdata = '0, cnt_in = '0;
  logic [15:0] bus_rdata, dport_wdata, cport_wdata;
  logic [7:0]  snd_wdata, unused_wdata;
  logic        dport_we, cport_we, snd_we, unused_we;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_rd = 16'h0000;

  always #4 clk = ~clk;

  vdp_port_decode i_vdp_port_decode (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:1] mk_addr(input logic [15:0] hi, input logic [5:0] off, input logic a1);
    return {hi, off, a1};
  endfunction

  function automatic logic [15:0] exp_word(input logic u, input logic l, input logic [15:0] d);
    if (u && l) return d;
    if (u) return {d[15:8], d[15:8]};
    return {d[7:0], d[7:0]};
  endfunction

  task automatic access(input logic wr, input logic [23:1] a, input logic u, input logic l,
                        input logic [15:0] wd, input string req);
    logic hitv;
    logic [5:0] offv;
    logic [3:0] exp_we;
    logic [15:0] exp_d;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_uds = u; bus_lds = l; bus_wdata = wd;
    dport_rdata = 16'($urandom); cport_rdata = 16'($urandom); cnt_in = 16'($urandom);
    hitv = a[23:8] == 16'hC000;
    offv = a[7:2];
    exp_we = 4'b0;
    if (hitv && wr && (u || l)) begin
      if (offv == 6'd0) exp_we[0] = 1'b1;
      if (offv == 6'd1) exp_we[1] = 1'b1;
      if ((offv == 6'd4 || offv == 6'd5) && l) exp_we[2] = 1'b1;
      if ((offv == 6'd4 || offv == 6'd5) && !l) exp_we[3] = 1'b1;
    end
    if (hitv && !wr) begin
      case (offv)
        6'd0: exp_rd = dport_rdata;
        6'd1: exp_rd = cport_rdata;
        6'd2: exp_rd = cnt_in;
        default: exp_rd = 16'hFFFF;
      endcase
    end
    exp_d = exp_word(u, l, wd);
    @(posedge clk);
    #1;
    cnt_in = ~cnt_in;
    chk({req, " strobes"}, {12'h0, unused_we, snd_we, cport_we, dport_we}, {12'h0, exp_we});
    chk({req, " rdata"}, bus_rdata, exp_rd);
    if (exp_we[0]) chk({req, " data word"}, dport_wdata, exp_d);
    if (exp_we[1]) chk({req, " ctrl word"}, cport_wdata, exp_d);
    if (exp_we[2]) chk({req, " snd byte"}, {8'h0, snd_wdata}, {8'h0, wd[7:0]});
    if (exp_we[3]) chk({req, " unused byte"}, {8'h0, unused_wdata}, {8'h0, wd[15:8]});
    @(negedge clk);
    bus_sel = 1'b0;
    @(posedge clk);
    #1;
    chk({req, " R3 pulse ends"}, {12'h0, unused_we, snd_we, cport_we, dport_we}, 16'h0);
    chk({req, " R8 rdata holds"}, bus_rdata, exp_rd);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset strobes", {12'h0, unused_we, snd_we, cport_we, dport_we}, 16'h0);
    chk("R1 reset rdata", bus_rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after reset rdata", bus_rdata, 16'h0000);

    access(1'b1, mk_addr(16'hC000, 6'd0, 1'b0), 1'b1, 1'b1, 16'h1234, "R3 data word");
    access(1'b1, mk_addr(16'hC000, 6'd1, 1'b1), 1'b1, 1'b1, 16'hA5C3, "R2 R3 ctrl mirror");
    access(1'b1, mk_addr(16'hC000, 6'd0, 1'b0), 1'b1, 1'b0, 16'h12EF, "R4 upper byte");
    access(1'b1, mk_addr(16'hC000, 6'd1, 1'b0), 1'b0, 1'b1, 16'h12EF, "R4 lower byte");
    access(1'b1, mk_addr(16'hC000, 6'd0, 1'b0), 1'b0, 1'b0, 16'h5555, "R5 no strobe");
    access(1'b1, mk_addr(16'hC000, 6'd4, 1'b1), 1'b0, 1'b1, 16'h009F, "R6 snd odd");
    access(1'b1, mk_addr(16'hC000, 6'd5, 1'b0), 1'b1, 1'b0, 16'h7700, "R7 snd even");
    access(1'b0, mk_addr(16'hC000, 6'd1, 1'b0), 1'b1, 1'b0, 16'h0, "R8 ctrl read upper");
    access(1'b0, mk_addr(16'hC000, 6'd0, 1'b1), 1'b0, 1'b0, 16'h0, "R8 data read no strobe");
    access(1'b0, mk_addr(16'hC000, 6'd2, 1'b0), 1'b1, 1'b1, 16'h0, "R9 counter read");
    access(1'b0, mk_addr(16'hC000, 6'd3, 1'b0), 1'b1, 1'b1, 16'h0, "R10 unmapped read");
    access(1'b1, mk_addr(16'hC000, 6'd2, 1'b0), 1'b1, 1'b1, 16'hBEEF, "R10 counter write");
    access(1'b1, mk_addr(16'hC000, 6'd9, 1'b0), 1'b1, 1'b1, 16'hBEEF, "R10 unmapped write");
    access(1'b1, mk_addr(16'hC001, 6'd0, 1'b0), 1'b1, 1'b1, 16'hBEEF, "R11 miss write");
    access(1'b0, mk_addr(16'h4000, 6'd1, 1'b0), 1'b1, 1'b1, 16'h0, "R11 miss read");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] o;
      logic [15:0] hi;
      o  = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'($urandom_range(0, 5));
      hi = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'hC000;
      access(1'($urandom), mk_addr(hi, o, 1'($urandom)), 1'($urandom), 1'($urandom),
             16'($urandom), "R2 R4 R6 R7 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule